// File: doc/BRIEF.md
# Fetch-Side Program Flow Trace Encoder

This block sits beside the instruction fetch stage of a pipelined core and turns what that stage does each clock into a compact trace record. Every clock it reports which kind of fetch took place and how many already-fetched instructions the pipeline threw away in that clock. Speculative fetches can therefore be corrected afterwards by software that holds the program image. The trace is taken at fetch rather than at retirement, because several instructions can retire in one clock and indirect targets are hard to recover late in the pipeline.

Only flow changes whose destination cannot be read from the code produce an address: indirect branches through the link or count register, interrupts and exceptions, return-from-interrupt, and writes to the machine state register. Those addresses wait in a small FIFO. They leave it one bit per clock on a serial line with a valid strobe, most significant bit first. A control input selects a serialized mode. In that mode every fetch address is shown directly on a parallel port and the compressed status is held at stall.

Top module: `fetch_trace_enc`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first event, `st_kind_o` is 0 (stall), `st_cancel_o` is 0, both flags are 0, and `tq_vld_o` and `vis_vld_o` are 0.
- R2: `st_kind_o` shows, one clock after it is given on `fe_kind_i`, the fetch kind coded as 0 stall, 1 sequential, 2 branch not taken, 3 direct branch taken, 4 indirect branch taken, 5 interrupt/exception taken. Input codes 6 and 7 are reported as 0.
- R3: `fe_ctx_chg_i` high marks a return-from-interrupt or machine-state write. That fetch is reported as code 4 and its address is queued, unless the kind is 5, which is kept.
- R4: Only codes 4 and 5, or a context change, queue an address. Codes 0 to 3 never cause serial output.
- R5: `st_cancel_o` shows `fe_flush_cnt_i` one clock later, saturated at 7.
- R6: `st_cancel_ovf_o` is set one clock after a flush count above 7. It stays set until a clock with `st_ack_i` high, and a new overflow in that clock wins.
- R7: Queued addresses are held in an 8-entry FIFO and leave in arrival order. Each one goes out as 32 consecutive clocks with `tq_vld_o` high and `tq_dat_o` MSB first, starting the clock after it is queued into an idle path. Words follow one another with no gap.
- R8: An address that arrives while 8 are held is dropped, and `st_lost_o` is set. It clears on a clock with `st_ack_i` high, and a new loss in that clock wins.
- R9: An indirect event and a nonzero flush in the same clock are both reported in the same output clock.
- R10: With `serial_mode_i` high, `st_kind_o` reads 0 and nothing is queued. `vis_vld_o` and `vis_addr_o` show every non-stall fetch one clock later, and `st_cancel_o` still reports. With the mode low, `vis_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| fe_kind_i | input | 3 | Fetch kind of this clock (codes per R2) |
| fe_ctx_chg_i | input | 1 | Fetch is a return-from-interrupt or machine-state write |
| fe_addr_i | input | 32 | Fetch target address |
| fe_flush_cnt_i | input | 4 | Instructions cancelled from the pipeline this clock |
| serial_mode_i | input | 1 | Selects serialized visibility mode |
| st_ack_i | input | 1 | Status read acknowledge, clears sticky flags |
| st_kind_o | output | 3 | Reported fetch kind |
| st_cancel_o | output | 3 | Saturated cancel count |
| st_cancel_ovf_o | output | 1 | Sticky cancel overflow flag |
| st_lost_o | output | 1 | Sticky lost-address flag |
| tq_dat_o | output | 1 | Serial target address bit |
| tq_vld_o | output | 1 | Serial bit valid |
| vis_addr_o | output | 32 | Fetch address in serialized mode |
| vis_vld_o | output | 1 | Fetch address valid in serialized mode |

## Verification
Two collisions matter most. The first is an indirect event together with a pipeline flush, which must show kind 4 and the cancel count in the same record. The second is a new address arriving in the clock a word finishes shifting while the FIFO is full. The bench provokes the first with a directed indirect fetch carrying a flush of 3, and it provokes the second with a burst of back-to-back indirect events that fills the queue during a serial transfer. A behavioural queue model judges every clock's status, flags and serial bits, and it fixes whether the colliding address is kept or dropped and when the next word's first bit appears.

// File: rtl/ftr_pkg.sv
package ftr_pkg;

  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    FK_STALL    = 3'd0,
    FK_SEQ      = 3'd1,
    FK_NOTTAKEN = 3'd2,
    FK_DIRECT   = 3'd3,
    FK_INDIRECT = 3'd4,
    FK_EXCEPT   = 3'd5
  } fkind_e;

endpackage

// File: rtl/ftr_classify.sv
module ftr_classify
  import ftr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_IN_W  = 4,
  parameter int CNT_OUT_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [KIND_W-1:0]    kind_i,
  input  logic                 ctx_chg_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [CNT_IN_W-1:0]  flush_cnt_i,
  input  logic                 serial_mode_i,
  input  logic                 ack_i,
  output logic                 push_o,
  output logic [KIND_W-1:0]    st_kind_o,
  output logic [CNT_OUT_W-1:0] st_cancel_o,
  output logic                 cancel_ovf_o,
  output logic [ADDR_W-1:0]    vis_addr_o,
  output logic                 vis_vld_o
);

  localparam int CNT_MAX = (1 << CNT_OUT_W) - 1;
  localparam logic [CNT_IN_W-1:0] CNT_MAX_IN = CNT_IN_W'(CNT_MAX);

  fkind_e                kind_eff;
  logic [KIND_W-1:0]     kind_d, kind_q;
  logic [CNT_OUT_W-1:0]  cancel_d, cancel_q;
  logic                  ovf_d, ovf_q;
  logic                  vis_vld_d, vis_vld_q;
  logic                  vis_en;
  logic [ADDR_W-1:0]     vis_addr_q;
  logic                  too_many;

  // Decode the raw kind; reserved codes collapse to stall, context changes
  // are promoted to an indirect flow change.
  always_comb begin
    unique case (kind_i)
      3'd1:    kind_eff = FK_SEQ;
      3'd2:    kind_eff = FK_NOTTAKEN;
      3'd3:    kind_eff = FK_DIRECT;
      3'd4:    kind_eff = FK_INDIRECT;
      3'd5:    kind_eff = FK_EXCEPT;
      default: kind_eff = FK_STALL;
    endcase
    if (ctx_chg_i && kind_eff != FK_EXCEPT) begin
      kind_eff = FK_INDIRECT;
    end
  end

  always_comb begin
    too_many  = flush_cnt_i > CNT_MAX_IN;
    cancel_d  = too_many ? CNT_OUT_W'(CNT_MAX) : flush_cnt_i[CNT_OUT_W-1:0];
    ovf_d     = too_many | (ovf_q & ~ack_i);
    kind_d    = serial_mode_i ? FK_STALL : kind_eff;
    push_o    = ~serial_mode_i & (kind_eff == FK_INDIRECT || kind_eff == FK_EXCEPT);
    vis_vld_d = serial_mode_i & (kind_eff != FK_STALL);
    vis_en    = vis_vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q    <= FK_STALL;
      cancel_q  <= '0;
      ovf_q     <= 1'b0;
      vis_vld_q <= 1'b0;
    end else begin
      kind_q    <= kind_d;
      cancel_q  <= cancel_d;
      ovf_q     <= ovf_d;
      vis_vld_q <= vis_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_addr_q <= '0;
    end else if (vis_en) begin
      vis_addr_q <= addr_i;
    end
  end

  assign st_kind_o    = kind_q;
  assign st_cancel_o  = cancel_q;
  assign cancel_ovf_o = ovf_q;
  assign vis_addr_o   = vis_addr_q;
  assign vis_vld_o    = vis_vld_q;

endmodule

// File: rtl/ftr_fifo.sv
module ftr_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  // A push against a full queue is refused even if a pop happens in the
  // same clock; the caller flags the loss.
  always_comb begin
    full_o  = (cnt_q == DEPTH_C);
    empty_o = (cnt_q == '0);
    do_push = push_i & ~full_o;
    do_pop  = pop_i & ~empty_o;
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (do_push) begin
      wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    end
    if (do_pop) begin
      rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    end
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic wen;
    assign wen = do_push && (wr_q == PTR_W'(e));
    always_ff @(posedge clk) begin
      if (wen) begin
        mem_q[e] <= data_i;
      end
    end
  end

  assign data_o = mem_q[rd_q];

endmodule

// File: rtl/ftr_serializer.sv
module ftr_serializer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         avail_i,
  input  logic [W-1:0] data_i,
  output logic         pop_o,
  output logic         ser_dat_o,
  output logic         ser_vld_o
);

  localparam int BIT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W - 1);

  logic             busy_q, busy_d;
  logic [W-1:0]     sh_q, sh_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             last;

  // A new word loads in the clock the previous one sends its last bit,
  // so consecutive words leave with no idle clock between them.
  always_comb begin
    last   = busy_q && (bit_q == LAST_BIT);
    pop_o  = avail_i && (!busy_q || last);
    busy_d = busy_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    if (pop_o) begin
      busy_d = 1'b1;
      sh_d   = data_i;
      bit_d  = '0;
    end else if (last) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      sh_d  = {sh_q[W-2:0], 1'b0};
      bit_d = bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '0;
      bit_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
    end
  end

  assign ser_vld_o = busy_q;
  assign ser_dat_o = sh_q[W-1];

endmodule

// File: rtl/fetch_trace_enc.sv
module fetch_trace_enc
  import ftr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_IN_W  = 4,
  parameter int CNT_OUT_W = 3,
  parameter int Q_DEPTH   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [KIND_W-1:0]    fe_kind_i,
  input  logic                 fe_ctx_chg_i,
  input  logic [ADDR_W-1:0]    fe_addr_i,
  input  logic [CNT_IN_W-1:0]  fe_flush_cnt_i,
  input  logic                 serial_mode_i,
  input  logic                 st_ack_i,
  output logic [KIND_W-1:0]    st_kind_o,
  output logic [CNT_OUT_W-1:0] st_cancel_o,
  output logic                 st_cancel_ovf_o,
  output logic                 st_lost_o,
  output logic                 tq_dat_o,
  output logic                 tq_vld_o,
  output logic [ADDR_W-1:0]    vis_addr_o,
  output logic                 vis_vld_o
);

  logic              push;
  logic              pop;
  logic              q_empty, q_full;
  logic [ADDR_W-1:0] q_head;
  logic              lost_q, lost_d;

  ftr_classify #(
    .ADDR_W   (ADDR_W),
    .CNT_IN_W (CNT_IN_W),
    .CNT_OUT_W(CNT_OUT_W)
  ) u_classify (
    .clk          (clk),
    .rst_n        (rst_n),
    .kind_i       (fe_kind_i),
    .ctx_chg_i    (fe_ctx_chg_i),
    .addr_i       (fe_addr_i),
    .flush_cnt_i  (fe_flush_cnt_i),
    .serial_mode_i(serial_mode_i),
    .ack_i        (st_ack_i),
    .push_o       (push),
    .st_kind_o    (st_kind_o),
    .st_cancel_o  (st_cancel_o),
    .cancel_ovf_o (st_cancel_ovf_o),
    .vis_addr_o   (vis_addr_o),
    .vis_vld_o    (vis_vld_o)
  );

  ftr_fifo #(
    .W    (ADDR_W),
    .DEPTH(Q_DEPTH)
  ) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (push),
    .data_i (fe_addr_i),
    .pop_i  (pop),
    .data_o (q_head),
    .empty_o(q_empty),
    .full_o (q_full)
  );

  ftr_serializer #(
    .W(ADDR_W)
  ) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .avail_i  (~q_empty),
    .data_i   (q_head),
    .pop_o    (pop),
    .ser_dat_o(tq_dat_o),
    .ser_vld_o(tq_vld_o)
  );

  always_comb begin
    lost_d = (push & q_full) | (lost_q & ~st_ack_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_q <= 1'b0;
    end else begin
      lost_q <= lost_d;
    end
  end

  assign st_lost_o = lost_q;

endmodule

// File: rtl/ftr_trace_chk.sv
module ftr_trace_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] flush,
  input logic       ser_mode,
  input logic       ack,
  input logic [2:0] kind_o,
  input logic [2:0] cancel_o,
  input logic       ovf_o,
  input logic       lost_o,
  input logic       vis_vld
);

  p_kind_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    kind_o <= 3'd5);

  p_cancel_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flush > 4'd7) |=> (cancel_o == 3'd7));

  p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush > 4'd7) |=> ovf_o);

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ack) |=> ovf_o);

  p_lost_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_o && !ack) |=> lost_o);

  p_serial_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ser_mode |=> (kind_o == 3'd0));

  p_vis_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_mode |=> !vis_vld);

endmodule

bind fetch_trace_enc ftr_trace_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .flush   (fe_flush_cnt_i),
  .ser_mode(serial_mode_i),
  .ack     (st_ack_i),
  .kind_o  (st_kind_o),
  .cancel_o(st_cancel_o),
  .ovf_o   (st_cancel_ovf_o),
  .lost_o  (st_lost_o),
  .vis_vld (vis_vld_o)
);

// File: tb/fetch_trace_enc_test.sv
`timescale 1ns/100ps
module fetch_trace_enc_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  kind;
  logic        ctx;
  logic [31:0] addr;
  logic [3:0]  flush;
  logic        smode;
  logic        ack;
  logic [2:0]  st_kind_o, st_cancel_o;
  logic        ovf_o, lost_o, tq_dat_o, tq_vld_o, vis_vld_o;
  logic [31:0] vis_addr_o;

  always #2.5 clk = ~clk;

  fetch_trace_enc uut (
    .clk(clk), .rst_n(rst_n), .fe_kind_i(kind), .fe_ctx_chg_i(ctx),
    .fe_addr_i(addr), .fe_flush_cnt_i(flush), .serial_mode_i(smode),
    .st_ack_i(ack), .st_kind_o(st_kind_o), .st_cancel_o(st_cancel_o),
    .st_cancel_ovf_o(ovf_o), .st_lost_o(lost_o), .tq_dat_o(tq_dat_o),
    .tq_vld_o(tq_vld_o), .vis_addr_o(vis_addr_o), .vis_vld_o(vis_vld_o)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // behavioural reference state
  int          e_kind, e_cancel;
  bit          e_ovf, e_lost, e_vld, e_vis_vld;
  logic [31:0] e_vis_addr, m_word;
  int          m_bit;
  logic [31:0] m_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    e_kind = 0; e_cancel = 0; e_ovf = 0; e_lost = 0; e_vld = 0;
    e_vis_vld = 0; e_vis_addr = '0; m_word = '0; m_bit = 0;
    m_q.delete();
  endtask

  task automatic model_step();
    int  k;
    bit  push, full_pre;
    k = (kind > 3'd5) ? 0 : int'(kind);
    if (ctx && k != 5) k = 4;
    push     = !smode && (k == 4 || k == 5);
    full_pre = (m_q.size() == 8);
    if (m_q.size() > 0 && (!e_vld || m_bit == 31)) begin
      m_word = m_q.pop_front(); e_vld = 1; m_bit = 0;
    end else if (e_vld) begin
      if (m_bit == 31) e_vld = 0;
      else begin m_word = m_word << 1; m_bit++; end
    end
    if (push && !full_pre) m_q.push_back(addr);
    e_lost   = (push && full_pre) || (e_lost && !ack);
    e_ovf    = (flush > 7) || (e_ovf && !ack);
    e_cancel = (flush > 7) ? 7 : int'(flush);
    e_kind   = smode ? 0 : k;
    e_vis_vld = smode && (k != 0);
    if (e_vis_vld) e_vis_addr = addr;
  endtask

  task automatic compare();
    chk("R2 kind", 32'(st_kind_o), 32'(e_kind));
    chk("R5 cancel", 32'(st_cancel_o), 32'(e_cancel));
    chk("R6 ovf", 32'(ovf_o), 32'(e_ovf));
    chk("R8 lost", 32'(lost_o), 32'(e_lost));
    chk("R7 vld", 32'(tq_vld_o), 32'(e_vld));
    if (e_vld) chk("R7 bit", 32'(tq_dat_o), 32'(m_word[31]));
    chk("R10 vis_vld", 32'(vis_vld_o), 32'(e_vis_vld));
    if (e_vis_vld) chk("R10 vis_addr", vis_addr_o, e_vis_addr);
  endtask

  task automatic cyc(input logic [2:0] k, input logic c, input logic [31:0] a,
                     input logic [3:0] f, input logic s, input logic ak);
    @(negedge clk);
    compare();
    kind = k; ctx = c; addr = a; flush = f; smode = s; ack = ak;
    model_step();
  endtask

  // sample right after the edge that consumes the last cyc() stimulus
  task automatic probe(input string tag, input logic [31:0] act_sel, input logic [31:0] exp);
    chk(tag, act_sel, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(3'd0, 1'b0, 32'h0, 4'd0, 1'b0, 1'b0);
  endtask

  initial begin
    #(5ns * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; kind = 0; ctx = 0; addr = 0; flush = 0; smode = 0; ack = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 kind", 32'(st_kind_o), 0);
    chk("R1 cancel", 32'(st_cancel_o), 0);
    chk("R1 flags", 32'({ovf_o, lost_o}), 0);
    chk("R1 valids", 32'({tq_vld_o, vis_vld_o}), 0);
    rst_n = 1'b1;
    model_step();

    // R2: every input code, reserved ones read as stall
    for (int k = 0; k < 8; k++) begin
      cyc(3'(k), 1'b0, 32'h1000 + 32'(k), 4'd0, 1'b0, 1'b0);
      @(posedge clk); #1;
      probe("R2 code", 32'(st_kind_o), (k > 5) ? 0 : k);
    end
    idle(8 * 33);

    // R4: codes 0..3 never produce serial output
    for (int k = 0; k < 4; k++) cyc(3'(k), 1'b0, 32'hFFFF_FFFF, 4'd0, 1'b0, 1'b0);
    idle(2);
    @(posedge clk); #1;
    probe("R4 no serial", 32'(tq_vld_o), 0);

    // R7: word into an idle path starts the clock after it is queued, MSB first
    cyc(3'd4, 1'b0, 32'h8000_0001, 4'd0, 1'b0, 1'b0);
    cyc(3'd0, 1'b0, 32'h0, 4'd0, 1'b0, 1'b0);
    @(posedge clk); #1;
    probe("R7 first vld", 32'(tq_vld_o), 1);
    probe("R7 msb", 32'(tq_dat_o), 1);
    idle(40);

    // R3: context change promoted to indirect, exception kept
    cyc(3'd1, 1'b1, 32'hA5A5_0000, 4'd0, 1'b0, 1'b0);
    @(posedge clk); #1;
    probe("R3 ctx->4", 32'(st_kind_o), 4);
    cyc(3'd5, 1'b1, 32'h0000_0500, 4'd0, 1'b0, 1'b0);
    @(posedge clk); #1;
    probe("R3 exc kept", 32'(st_kind_o), 5);
    idle(80);

    // R9: indirect and flush together
    cyc(3'd4, 1'b0, 32'h1234_5678, 4'd3, 1'b0, 1'b0);
    @(posedge clk); #1;
    probe("R9 kind", 32'(st_kind_o), 4);
    probe("R9 cancel", 32'(st_cancel_o), 3);
    idle(40);

    // R5 / R6: saturation and sticky overflow
    cyc(3'd1, 1'b0, 32'h0, 4'd7, 1'b0, 1'b0);
    @(posedge clk); #1;
    probe("R5 seven", 32'(st_cancel_o), 7);
    probe("R6 no ovf at 7", 32'(ovf_o), 0);
    cyc(3'd1, 1'b0, 32'h0, 4'd12, 1'b0, 1'b0);
    @(posedge clk); #1;
    probe("R5 sat", 32'(st_cancel_o), 7);
    probe("R6 ovf", 32'(ovf_o), 1);
    idle(3);
    cyc(3'd0, 1'b0, 32'h0, 4'd0, 1'b0, 1'b1);
    @(posedge clk); #1;
    probe("R6 ack clears", 32'(ovf_o), 0);
    cyc(3'd0, 1'b0, 32'h0, 4'd15, 1'b0, 1'b1);
    @(posedge clk); #1;
    probe("R6 set wins", 32'(ovf_o), 1);
    cyc(3'd0, 1'b0, 32'h0, 4'd0, 1'b0, 1'b1);

    // R8: burst overflows the queue during transfer
    for (int i = 0; i < 11; i++) cyc(3'd4, 1'b0, 32'hC000_0000 + 32'(i), 4'd0, 1'b0, 1'b0);
    @(posedge clk); #1;
    probe("R8 lost", 32'(lost_o), 1);
    idle(4);
    cyc(3'd0, 1'b0, 32'h0, 4'd0, 1'b0, 1'b1);
    @(posedge clk); #1;
    probe("R8 ack clears", 32'(lost_o), 0);
    idle(10 * 33);

    // R10: serialized mode
    cyc(3'd1, 1'b0, 32'hDEAD_BEEF, 4'd2, 1'b1, 1'b0);
    @(posedge clk); #1;
    probe("R10 vis_vld", 32'(vis_vld_o), 1);
    probe("R10 vis_addr", vis_addr_o, 32'hDEAD_BEEF);
    probe("R10 kind stall", 32'(st_kind_o), 0);
    probe("R10 cancel", 32'(st_cancel_o), 2);
    cyc(3'd4, 1'b0, 32'h0BAD_0000, 4'd0, 1'b1, 1'b0);
    cyc(3'd0, 1'b0, 32'h0, 4'd0, 1'b1, 1'b0);
    @(posedge clk); #1;
    probe("R10 no queue", 32'(tq_vld_o), 0);
    probe("R10 stall hides", 32'(vis_vld_o), 0);

    // mixed random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      cyc(3'($urandom_range(0, 7)), ($urandom_range(0, 15) == 0),
          $urandom(), 4'($urandom_range(0, 9)),
          ($urandom_range(0, 9) == 0), ($urandom_range(0, 7) == 0));
    end
    idle(9 * 33);
    @(negedge clk);
    compare();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule